// File: doc/BRIEF.md
# MOSI Snooping Coherence Controller

This block holds the coherence bookkeeping for a small direct-mapped cache attached to a shared snooping bus. It keeps one address tag and one of four line states per line: Invalid, Shared, Owner and Modified. The data payload is held elsewhere. Processor requests arrive on a valid/ready port. Each request is a load, a store or a replacement. The block decides whether the request can finish locally. When it cannot, it raises a bus request with the transaction that the line state calls for. Transactions from other caches arrive on a snoop port. They move line states, and they flag when this cache must provide the line's data.

The processor port follows valid/ready rules. After `cpu_valid` rises, the address and operation stay stable until `cpu_ready` is seen high at a clock edge. A request that needs the bus keeps `cpu_ready` low until `bus_gnt` is high in the same cycle as `bus_req`. The line state is written at that edge. A conflict eviction is the one exception: its writeback grant only empties the line, and the fill request follows on the next cycle. Snoops are never stalled. A cycle with `snp_valid` high withholds both `cpu_ready` and `bus_req`, so the processor request is evaluated again afterwards against the state the snoop left behind.

Top module: `mosi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. `bus_req` and `snp_supply` are low. A store to any address then needs a read-to-write.
- R2: A load (cpu_op 0) whose tag misses an Invalid line raises `bus_req` with bus_op 0 (read-to-share) at the requested address. `cpu_ready` stays low until `bus_gnt`. The line becomes Shared.
- R3: A store (cpu_op 1) to an Invalid line requests bus_op 1 (read-to-write). When granted it completes, and the line becomes Modified.
- R4: A store that hits a Shared or Owner line requests only bus_op 3 (invalidate). When granted the line becomes Modified.
- R5: A load that hits a Shared, Owner or Modified line, or a store that hits a Modified line, completes in the same cycle with `cpu_hit` high, no bus request and no state change.
- R6: A replacement (cpu_op 2) of a Modified or Owner line requests bus_op 2 (writeback) and leaves the line Invalid. Replacing a Shared line invalidates it without a bus request. Replacing an address that is not present completes at once with no effect. Code 3 completes at once with no effect.
- R7: A load or store whose tag differs from a valid line at its index first evicts that line. An Owner or Modified victim takes a writeback of the victim address, and a separate grant is needed before the fill. A Shared victim is overwritten by the fill directly.
- R8: A snooped read-to-share (snp_op 0) that hits a Modified line asserts `snp_supply` and leaves the line Owner. On an Owner line it supplies and stays Owner. On a Shared line it neither supplies nor changes the state.
- R9: A snooped read-to-write (snp_op 1) that hits a Modified or Owner line asserts `snp_supply` and invalidates the line. On a Shared line it invalidates without supplying.
- R10: A snooped invalidate (snp_op 3) that hits any valid line leaves it Invalid with no supply. A snooped writeback (snp_op 2) has no effect.
- R11: A snoop whose tag does not match the line at its index causes no supply and no state change.
- R12: While `snp_valid` is high, `cpu_ready` and `bus_req` are low. The processor request is retried on the next cycle against the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | 0 load, 1 store, 2 replace, 3 no operation |
| cpu_addr | input | ADDR_W | Line address: tag above, index in the low IDX_W bits |
| cpu_ready | output | 1 | Request completes at this edge |
| cpu_hit | output | 1 | Completion needed no bus transaction |
| bus_req | output | 1 | Bus transaction wanted |
| bus_op | output | 2 | 0 read-to-share, 1 read-to-write, 2 writeback, 3 invalidate |
| bus_addr | output | ADDR_W | Line address of the transaction |
| bus_gnt | input | 1 | Transaction granted this cycle |
| snp_valid | input | 1 | Foreign bus transaction present |
| snp_op | input | 2 | Snooped transaction code, same encoding as bus_op |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_supply | output | 1 | This cache must provide the line data |

## Verification
All outputs are combinational functions of the present inputs and the stored line state. `cpu_ready`, `cpu_hit`, `bus_req` and `snp_supply` are therefore due in the same cycle as their stimulus. A state change is visible from the cycle after the clock edge that accepts it. The bench drives inputs at the falling edge and samples one time unit later. It reads a line's state non-destructively: it offers a store without a grant and a read-to-share snoop, and withdraws both before the next rising edge. Each scenario is built from reset, and its final state and bus sequence are compared with values derived from the requirements.

// File: rtl/mosi_pkg.sv
package mosi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_O = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    CPU_LOAD  = 2'd0,
    CPU_STORE = 2'd1,
    CPU_REPL  = 2'd2,
    CPU_NOP   = 2'd3
  } cpu_op_e;

  typedef enum logic [1:0] {
    BUS_RTS = 2'd0,
    BUS_RTW = 2'd1,
    BUS_WB  = 2'd2,
    BUS_INV = 2'd3
  } bus_op_e;
endpackage

// File: rtl/mosi_line_store.sv
module mosi_line_store
  import mosi_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output logic [TAG_W-1:0] a_tag,
  output line_st_e         a_st,
  input  logic [IDX_W-1:0] b_idx,
  output logic [TAG_W-1:0] b_tag,
  output line_st_e         b_st,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  line_st_e         wr_st
);
  localparam int LINES = 1 << IDX_W;

  line_st_e         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_idx]  <= wr_st;
      tag_q[wr_idx] <= wr_tag;
    end
  end

  assign a_tag = tag_q[a_idx];
  assign a_st  = st_q[a_idx];
  assign b_tag = tag_q[b_idx];
  assign b_st  = st_q[b_idx];
endmodule

// File: rtl/mosi_cpu_side.sv
module mosi_cpu_side
  import mosi_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             valid,
  input  cpu_op_e          op,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  line_st_e         line_st,
  input  logic             blocked,
  input  logic             gnt,
  output logic             ready,
  output logic             hit,
  output logic             req,
  output bus_op_e          req_op,
  output logic [TAG_W-1:0] req_bus_tag,
  output logic             wr_en,
  output logic [TAG_W-1:0] wr_tag,
  output line_st_e         wr_st
);
  logic     present, occupied, dirty;
  logic     need_bus, evict_first, change;
  line_st_e nxt;

  assign occupied = (line_st != ST_I);
  assign present  = occupied && (line_tag == req_tag);
  assign dirty    = (line_st == ST_M) || (line_st == ST_O);

  always_comb begin
    need_bus    = 1'b0;
    evict_first = 1'b0;
    change      = 1'b0;
    req_op      = BUS_RTS;
    req_bus_tag = req_tag;
    nxt         = line_st;
    wr_tag      = line_tag;
    unique case (op)
      CPU_LOAD, CPU_STORE: begin
        if (present) begin
          if (op == CPU_STORE && line_st != ST_M) begin
            need_bus = 1'b1;
            req_op   = BUS_INV;
            nxt      = ST_M;
          end
        end else if (occupied && dirty) begin
          need_bus    = 1'b1;
          evict_first = 1'b1;
          req_op      = BUS_WB;
          req_bus_tag = line_tag;
          nxt         = ST_I;
        end else begin
          need_bus = 1'b1;
          req_op   = (op == CPU_STORE) ? BUS_RTW : BUS_RTS;
          nxt      = (op == CPU_STORE) ? ST_M : ST_S;
          wr_tag   = req_tag;
        end
      end
      CPU_REPL: begin
        if (present) begin
          nxt = ST_I;
          if (dirty) begin
            need_bus = 1'b1;
            req_op   = BUS_WB;
          end else begin
            change = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  assign req   = valid && !blocked && need_bus;
  assign ready = valid && !blocked && (!need_bus || (gnt && !evict_first));
  assign hit   = ready && !need_bus;
  assign wr_en = valid && !blocked && (need_bus ? gnt : change);
  assign wr_st = nxt;
endmodule

// File: rtl/mosi_snoop_side.sv
module mosi_snoop_side
  import mosi_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             valid,
  input  bus_op_e          op,
  input  logic [TAG_W-1:0] snp_tag,
  input  logic [TAG_W-1:0] line_tag,
  input  line_st_e         line_st,
  output logic             supply,
  output logic             wr_en,
  output line_st_e         wr_st
);
  logic match, dirty;

  assign match = valid && (line_st != ST_I) && (line_tag == snp_tag);
  assign dirty = (line_st == ST_M) || (line_st == ST_O);

  always_comb begin
    supply = 1'b0;
    wr_en  = 1'b0;
    wr_st  = line_st;
    if (match) begin
      unique case (op)
        BUS_RTS: begin
          supply = dirty;
          if (line_st == ST_M) begin
            wr_en = 1'b1;
            wr_st = ST_O;
          end
        end
        BUS_RTW: begin
          supply = dirty;
          wr_en  = 1'b1;
          wr_st  = ST_I;
        end
        BUS_INV: begin
          wr_en = 1'b1;
          wr_st = ST_I;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mosi_snoop_ctrl.sv
module mosi_snoop_ctrl
  import mosi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              cpu_hit,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_supply
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] c_idx, s_idx, w_idx;
  logic [TAG_W-1:0] c_tag, s_tag, c_line_tag, s_line_tag, c_bus_tag;
  logic [TAG_W-1:0] c_wr_tag, w_tag;
  line_st_e         c_line_st, s_line_st, c_wr_st, s_wr_st, w_st;
  logic             c_wr_en, s_wr_en, w_en;
  bus_op_e          c_bus_op;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  mosi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(c_idx), .a_tag(c_line_tag), .a_st(c_line_st),
    .b_idx(s_idx), .b_tag(s_line_tag), .b_st(s_line_st),
    .wr_en(w_en), .wr_idx(w_idx), .wr_tag(w_tag), .wr_st(w_st)
  );

  mosi_cpu_side #(.TAG_W(TAG_W)) u_cpu (
    .valid(cpu_valid), .op(cpu_op_e'(cpu_op)), .req_tag(c_tag),
    .line_tag(c_line_tag), .line_st(c_line_st),
    .blocked(snp_valid), .gnt(bus_gnt),
    .ready(cpu_ready), .hit(cpu_hit),
    .req(bus_req), .req_op(c_bus_op), .req_bus_tag(c_bus_tag),
    .wr_en(c_wr_en), .wr_tag(c_wr_tag), .wr_st(c_wr_st)
  );

  mosi_snoop_side #(.TAG_W(TAG_W)) u_snp (
    .valid(snp_valid), .op(bus_op_e'(snp_op)), .snp_tag(s_tag),
    .line_tag(s_line_tag), .line_st(s_line_st),
    .supply(snp_supply), .wr_en(s_wr_en), .wr_st(s_wr_st)
  );

  // Snoop writes win; the CPU side is already blocked while a snoop is present.
  assign w_en  = s_wr_en || c_wr_en;
  assign w_idx = s_wr_en ? s_idx : c_idx;
  assign w_tag = s_wr_en ? s_line_tag : c_wr_tag;
  assign w_st  = s_wr_en ? s_wr_st : c_wr_st;

  assign bus_op   = c_bus_op;
  assign bus_addr = {c_bus_tag, c_idx};
endmodule

// File: rtl/mosi_snoop_ctrl_chk.sv
module mosi_snoop_ctrl_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic [1:0]        cpu_op,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              snp_valid,
  input logic [1:0]        snp_op,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              snp_supply
);
  AST_SNOOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!cpu_ready && !bus_req)); // R12

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid); // R2

  AST_WAIT_FOR_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |-> !cpu_ready); // R2

  AST_SUPPLY_ON_READS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_valid && (snp_op == 2'd0 || snp_op == 2'd1))); // R8

  AST_STORE_THEN_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_valid && cpu_ready && cpu_op == 2'd1) && cpu_valid &&
     cpu_op == 2'd0 && cpu_addr == $past(cpu_addr) && !snp_valid)
    |-> (cpu_ready && !bus_req)); // R5

  AST_OWNER_KEEPS_SUPPLYING: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(snp_supply && snp_op == 2'd0) && snp_valid && snp_op == 2'd0 &&
     snp_addr == $past(snp_addr)) |-> snp_supply); // R8

  AST_RTW_LEAVES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(snp_valid && snp_op == 2'd1) && snp_valid &&
     snp_addr == $past(snp_addr)) |-> !snp_supply); // R9
endmodule

bind mosi_snoop_ctrl mosi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
  .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
  .snp_supply(snp_supply)
);

// File: tb/tb_mosi_snoop_ctrl.sv
module tb_mosi_snoop_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int IDX_W  = 2;
  localparam int LINES  = 1 << IDX_W;
  // state codes used by the bench: 0 I, 1 S, 2 O, 3 M
  localparam int SI = 0, SS = 1, SO = 2, SM = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0;
  logic [1:0] cpu_op = '0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic cpu_ready, cpu_hit, bus_req, snp_supply;
  logic [1:0] bus_op;
  logic [ADDR_W-1:0] bus_addr;
  logic bus_gnt = 1'b0;
  logic snp_valid = 1'b0;
  logic [1:0] snp_op = '0;
  logic [ADDR_W-1:0] snp_addr = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mosi_snoop_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
    .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
    .snp_supply(snp_supply)
  );

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    checks++; errors++;
    $display("FAIL R12 watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_valid = 1'b0; snp_valid = 1'b0; bus_gnt = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Runs one processor request to completion, granting every bus request.
  task automatic cpu_access(input int op, input logic [ADDR_W-1:0] a,
                            output int nb, output int ops[2], output int adr[2],
                            output bit hit);
    bit fin = 0;
    nb = 0; hit = 0; ops[0] = -1; ops[1] = -1; adr[0] = -1; adr[1] = -1;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = 2'(op); cpu_addr = a; bus_gnt = 1'b0;
    for (int k = 0; k < 4 && !fin; k++) begin
      #1;
      if (cpu_ready) begin
        hit = cpu_hit; fin = 1;
      end else if (bus_req) begin
        if (nb < 2) begin ops[nb] = bus_op; adr[nb] = bus_addr; end
        nb++;
        bus_gnt = 1'b1;
        #1;
        if (cpu_ready) fin = 1;
      end
      @(negedge clk);
      bus_gnt = 1'b0;
    end
    cpu_valid = 1'b0;
  endtask

  task automatic snoop(input int op, input logic [ADDR_W-1:0] a, output bit sup);
    @(negedge clk);
    snp_valid = 1'b1; snp_op = 2'(op); snp_addr = a;
    #1 sup = snp_supply;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  // Non-destructive state read within a single low clock phase.
  task automatic probe(input logic [ADDR_W-1:0] a, output int st);
    bit inv;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = 2'd1; cpu_addr = a; bus_gnt = 1'b0;
    #1;
    inv = bus_req && bus_op == 2'd3;
    if (cpu_ready && cpu_hit) st = SM;
    else st = SI;
    cpu_valid = 1'b0;
    #1;
    if (inv) begin
      snp_valid = 1'b1; snp_op = 2'd0; snp_addr = a;
      #1 st = snp_supply ? SO : SS;
      snp_valid = 1'b0;
    end
  endtask

  task automatic setup(input int st, input logic [ADDR_W-1:0] a);
    int nb; int ops[2]; int adr[2]; bit h, sup;
    do_reset();
    if (st == SS) cpu_access(0, a, nb, ops, adr, h);
    if (st == SM || st == SO) cpu_access(1, a, nb, ops, adr, h);
    if (st == SO) snoop(0, a, sup);
  endtask

  function automatic string req_of(int st, int stim);
    case (stim)
      0: return (st == SI) ? "R2" : "R5";
      1: return (st == SI) ? "R3" : (st == SM) ? "R5" : "R4";
      2: return "R6";
      3: return "R8";
      4: return "R9";
      5, 6: return "R10";
      7, 8, 9: return "R11";
      default: return "R7";
    endcase
  endfunction

  initial begin
    int nb; int ops[2]; int adr[2]; bit h, sup; int st;
    do_reset();
    #1;
    chk(!bus_req && !snp_supply, "R1 idle outputs", {bus_req, snp_supply}, 0);
    for (int i = 0; i < LINES; i++) begin
      probe(ADDR_W'(i), st);
      chk(st == SI, "R1 reset state", st, SI);
    end

    for (int idx = 0; idx < LINES; idx++) begin
      for (int s0 = 0; s0 < 4; s0++) begin
        for (int stim = 0; stim < 12; stim++) begin
          logic [ADDR_W-1:0] a, b, pa;
          int e_nb, e_st; int e_op[2]; int e_ad[2]; bit e_hit, e_sup, is_cpu;
          string r;
          a = {4'(1 + idx), 2'(idx)};
          b = {4'(9 + idx), 2'(idx)};
          r = req_of(s0, stim);
          setup(s0, a);
          e_nb = 0; e_op[0] = -1; e_op[1] = -1; e_ad[0] = -1; e_ad[1] = -1;
          e_hit = 0; e_sup = 0; e_st = s0; pa = a; is_cpu = 1;
          case (stim)
            0: if (s0 == SI) begin e_nb = 1; e_op[0] = 0; e_ad[0] = a; e_st = SS; end
               else e_hit = 1;
            1: if (s0 == SI) begin e_nb = 1; e_op[0] = 1; e_ad[0] = a; e_st = SM; end
               else if (s0 == SM) e_hit = 1;
               else begin e_nb = 1; e_op[0] = 3; e_ad[0] = a; e_st = SM; end
            2: begin
                 e_st = SI;
                 if (s0 == SM || s0 == SO) begin e_nb = 1; e_op[0] = 2; e_ad[0] = a; end
                 else e_hit = 1;
               end
            10, 11: begin
                 pa = b;
                 e_st = (stim == 10) ? SS : SM;
                 if (s0 == SM || s0 == SO) begin
                   e_nb = 2; e_op[0] = 2; e_ad[0] = a;
                   e_op[1] = stim - 10; e_ad[1] = b;
                 end else begin
                   e_nb = 1; e_op[0] = stim - 10; e_ad[0] = b;
                 end
               end
            default: begin
                 is_cpu = 0;
                 if (stim == 3) begin
                   e_sup = (s0 == SM || s0 == SO);
                   if (s0 == SM) e_st = SO;
                 end else if (stim == 4) begin
                   e_sup = (s0 == SM || s0 == SO); e_st = SI;
                 end else if (stim == 5) e_st = SI;
               end
          endcase
          if (is_cpu) begin
            cpu_access(stim >= 10 ? stim - 10 : stim, pa, nb, ops, adr, h);
            chk(nb == e_nb, {r, " bus count"}, nb, e_nb);
            chk(ops[0] == e_op[0] && ops[1] == e_op[1], {r, " bus ops"},
                ops[0] * 4 + ops[1], e_op[0] * 4 + e_op[1]);
            chk(adr[0] == e_ad[0] && adr[1] == e_ad[1], {r, " bus addr"}, adr[0], e_ad[0]);
            chk(h == e_hit, {r, " hit"}, h, e_hit);
          end else begin
            snoop(stim == 6 ? 2 : (stim == 3 || stim == 7) ? 0 :
                  (stim == 4 || stim == 8) ? 1 : 3, stim >= 7 ? b : a, sup);
            chk(sup == e_sup, {r, " supply"}, sup, e_sup);
          end
          probe(pa, st);
          chk(st == e_st, {r, " final state"}, st, e_st);
        end
      end
    end

    // R6: code 3 completes immediately and leaves a Modified line alone
    setup(SM, 6'h05);
    cpu_access(3, 6'h05, nb, ops, adr, h);
    chk(h && nb == 0, "R6 no-op code", nb, 0);
    probe(6'h05, st);
    chk(st == SM, "R6 no-op state", st, SM);

    // R12: snoop on another line blocks an unrelated request for that cycle
    setup(SM, 6'h04);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = 2'd0; cpu_addr = 6'h09;
    snp_valid = 1'b1; snp_op = 2'd0; snp_addr = 6'h04;
    #1;
    chk(!cpu_ready && !bus_req, "R12 blocked", {cpu_ready, bus_req}, 0);
    chk(snp_supply, "R12 snoop served", snp_supply, 1);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    chk(bus_req && bus_op == 2'd0, "R12 retried", bus_op, 0);
    cpu_valid = 1'b0;
    probe(6'h04, st);
    chk(st == SO, "R12 snoop applied", st, SO);

    // R12: a store upgrade loses the race to a foreign read-to-write
    setup(SS, 6'h06);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = 2'd1; cpu_addr = 6'h06;
    snp_valid = 1'b1; snp_op = 2'd1; snp_addr = 6'h06;
    #1;
    chk(!snp_supply && !cpu_ready, "R12 race blocked", snp_supply, 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    chk(bus_req && bus_op == 2'd1, "R12 race reissued as read-to-write", bus_op, 1);
    bus_gnt = 1'b1;
    #1;
    chk(cpu_ready, "R12 race completes", cpu_ready, 1);
    @(negedge clk);
    bus_gnt = 1'b0; cpu_valid = 1'b0;
    probe(6'h06, st);
    chk(st == SM, "R12 race final", st, SM);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule